// File: doc/BRIEF.md
# Lock-Tagged Transmit Buffer Controller

This block is the terminal-side reader that feeds outgoing message data to a serializer. Host software keeps one table pointer per subaddress in a pointer table in shared RAM. Each table begins with a tag word followed by the data words. When a transmit request arrives for a subaddress, the block reads that pointer once and keeps its own copy. It then updates the tag word in a single locked read-modify-write: it sets the in-use flag and clears the fresh-data flag. After that it streams the requested number of words to the serializer through a valid/ready handshake. When the message ends, it clears the in-use flag again.

The in-use flag tells the host that a table is still being read. The host therefore refills only tables whose flag is clear, and it may repoint a subaddress at any moment without mixing old and new words into one message. The fresh-data flag, taken when the message starts, is reported to the serializer side for the whole message. An abort input ends a message early. An abort never leaves a table marked in use.

Top module: `txbuf_lock_ctrl`

## Requirements
- R1: After reset, `busy`, `msg_done`, `fresh_data`, `lock_held`, `tx_valid` and `mem_req` are all 0.
- R2: On an accepted request, the table pointer is read once from address `PTR_BASE + req_sa` (low `AW` bits of the word). A later host write to that pointer entry does not change the words sent in the running message.
- R3: The tag word at the table pointer is read and then written back at the same address. `mem_lock` is held high from the read request to the granted write. The written value has bit 15 (in-use) set and bit 14 (fresh) cleared, with bits 13..0 unchanged.
- R4: Data words are read from `ptr+1` to `ptr+N` in ascending order. Each is offered on `tx_data` with `tx_valid`, and held stable until `tx_ready` is high at a clock edge.
- R5: A `req_count` of 0 means 2^`CNT_W` words (32 by default). Any other value means exactly that many words.
- R6: `fresh_data` equals bit 14 of the tag word as read at message start. It is valid from the first offered word until `msg_done`, and is 0 when no word was offered.
- R7: After the last word is accepted, the tag word is read again under `mem_lock` and written back with bit 15 cleared and all other bits as read.
- R8: `abort` is ignored while idle. An abort taken before the tag update ends the message with no RAM write. An abort taken after the tag update stops the words and still clears bit 15.
- R9: `busy` is high from the cycle after a request is accepted until the end of the one-cycle `msg_done` pulse that ends each message.
- R10: While `mem_req` is high without `mem_gnt`, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values, unless an abort arrives.
- R11: `lock_held` is high from the granted tag write that sets bit 15 until the granted write that clears it, and is 0 whenever `msg_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transmit request, taken while idle |
| req_sa | input | SA_W | Subaddress that selects the pointer entry |
| req_count | input | CNT_W | Word count, 0 meaning 2^CNT_W |
| abort | input | 1 | End the running message early |
| busy | output | 1 | Message in progress |
| msg_done | output | 1 | One-cycle end-of-message pulse |
| fresh_data | output | 1 | Fresh flag of the table being sent |
| lock_held | output | 1 | Table currently marked in use by this block |
| mem_req | output | 1 | RAM access request |
| mem_we | output | 1 | RAM write enable |
| mem_lock | output | 1 | Keep the arbiter locked to this block (atomic tag update) |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | DW | RAM write data |
| mem_gnt | input | 1 | Access granted in this cycle |
| mem_rdata | input | DW | Read data, valid the cycle after a granted read |
| tx_valid | output | 1 | Data word offered to the serializer |
| tx_data | output | DW | Data word |
| tx_ready | input | 1 | Serializer takes the word |

## Verification
The bench moves the pointer entry while a message is being read. A design that re-read the pointer would switch tables part-way through and send words from two tables. It aborts both while the grant is held off before the tag update and after several words. A design that wrote RAM too early would leave a table marked in use, and one that skipped the unlock on abort would leave the in-use bit set. It requests a count of 0, which a design with a naive last-word compare would turn into zero or one word. It checks the tag word seen during transfer and after it, to catch a tag update that drops the lower bits or leaves the fresh flag set.

// File: rtl/txb_pkg.sv
package txb_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PTR_RD,
      S_PTR_WT,
      S_TAG_RD,
      S_TAG_WT,
      S_TAG_WR,
      S_DAT_RD,
      S_DAT_WT,
      S_DAT_OUT,
      S_UNL_RD,
      S_UNL_WT,
      S_UNL_WR,
      S_FIN
   } txb_state_e;

   // States in which the arbiter must stay with this block
   function automatic logic txb_locked_state(txb_state_e s);
      return (s == S_TAG_RD) || (s == S_TAG_WT) || (s == S_TAG_WR) ||
             (s == S_UNL_RD) || (s == S_UNL_WT) || (s == S_UNL_WR);
   endfunction

endpackage

// File: rtl/txb_tag_fmt.sv
module txb_tag_fmt #(
   parameter int DW       = 16,
   parameter int LOCK_BIT = 15,
   parameter int UPD_BIT  = 14
) (
   input  logic [DW-1:0] tag_in,
   output logic [DW-1:0] lock_word,
   output logic [DW-1:0] unlock_word
);
   localparam logic [DW-1:0] LMASK = DW'(1) << LOCK_BIT;
   localparam logic [DW-1:0] UMASK = DW'(1) << UPD_BIT;

   // Claim: set in-use, consume fresh; every other bit passes through
   assign lock_word   = (tag_in | LMASK) & ~UMASK;
   // Release: drop in-use only
   assign unlock_word = tag_in & ~LMASK;
endmodule

// File: rtl/txb_addr_gen.sv
module txb_addr_gen
   import txb_pkg::*;
#(
   parameter int AW       = 12,
   parameter int SA_W     = 5,
   parameter int CNT_W    = 5,
   parameter int PTR_BASE = 0
) (
   input  txb_state_e       state,
   input  logic [SA_W-1:0]  sa,
   input  logic [AW-1:0]    ptr,
   input  logic [CNT_W-1:0] idx,
   output logic [AW-1:0]    addr
);
   localparam logic [AW-1:0] BASE = AW'(PTR_BASE);

   always_comb begin
      unique case (state)
         S_PTR_RD, S_PTR_WT:                 addr = BASE + AW'(sa);
         S_TAG_RD, S_TAG_WT, S_TAG_WR,
         S_UNL_RD, S_UNL_WT, S_UNL_WR:       addr = ptr;
         S_DAT_RD, S_DAT_WT, S_DAT_OUT:      addr = ptr + AW'(1) + AW'(idx);
         default:                            addr = '0;
      endcase
   end
endmodule

// File: rtl/txb_word_reg.sv
module txb_word_reg #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dout <= '0;
      else if (load) dout <= din;
   end
endmodule

// File: rtl/txbuf_lock_ctrl.sv
module txbuf_lock_ctrl
   import txb_pkg::*;
#(
   parameter int DW         = 16,
   parameter int AW         = 12,
   parameter int NUM_SA     = 32,
   parameter int CNT_W      = 5,
   parameter int PTR_BASE   = 0,
   parameter int LOCK_BIT   = 15,
   parameter int UPD_BIT    = 14,
   parameter bit UNLOCK_RMW = 1'b1,
   localparam int SA_W      = $clog2(NUM_SA)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [SA_W-1:0]  req_sa,
   input  logic [CNT_W-1:0] req_count,
   input  logic             abort,
   output logic             busy,
   output logic             msg_done,
   output logic             fresh_data,
   output logic             lock_held,
   output logic             mem_req,
   output logic             mem_we,
   output logic             mem_lock,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_gnt,
   input  logic [DW-1:0]    mem_rdata,
   output logic             tx_valid,
   output logic [DW-1:0]    tx_data,
   input  logic             tx_ready
);

   // ---------------- elaboration checks ----------------
   if (LOCK_BIT >= DW || UPD_BIT >= DW || LOCK_BIT == UPD_BIT) begin : g_bad_tag
      $error("tag flag positions must be distinct and inside the word");
   end
   if (AW > DW) begin : g_bad_aw
      $error("a pointer must fit in one RAM word");
   end
   if (PTR_BASE + NUM_SA > (1 << AW)) begin : g_bad_base
      $error("pointer table does not fit in the address space");
   end
   if (NUM_SA < 2) begin : g_bad_sa
      $error("at least two subaddresses are required");
   end

   // ---------------- state ----------------
   txb_state_e       state, nxt;
   logic [SA_W-1:0]  sa_q;
   logic [CNT_W-1:0] cnt_q, idx_q;
   logic [AW-1:0]    ptr_q;
   logic [DW-1:0]    tag_q;
   logic             fresh_q, seen_q, abort_pend_q, lock_q;
   logic [DW-1:0]    lock_word, unlock_word;
   logic             last_word;
   txb_state_e       unl_entry;

   // Release path: re-read the tag under lock, or write back the saved claim
   if (UNLOCK_RMW) begin : g_unl_rmw
      assign unl_entry = S_UNL_RD;
   end else begin : g_unl_direct
      assign unl_entry = S_UNL_WR;
   end

   // count 0 wraps so the compare hits after 2^CNT_W words
   assign last_word = (idx_q == cnt_q - CNT_W'(1));

   always_comb begin
      nxt = state;
      unique case (state)
         S_IDLE:    if (req_valid) nxt = S_PTR_RD;
         S_PTR_RD:  if (abort_pend_q) nxt = S_FIN;
                    else if (mem_gnt) nxt = S_PTR_WT;
         S_PTR_WT:  nxt = abort_pend_q ? S_FIN : S_TAG_RD;
         S_TAG_RD:  if (abort_pend_q) nxt = S_FIN;
                    else if (mem_gnt) nxt = S_TAG_WT;
         S_TAG_WT:  nxt = S_TAG_WR;
         S_TAG_WR:  if (mem_gnt) nxt = abort_pend_q ? unl_entry : S_DAT_RD;
         S_DAT_RD:  if (abort_pend_q) nxt = unl_entry;
                    else if (mem_gnt) nxt = S_DAT_WT;
         S_DAT_WT:  nxt = abort_pend_q ? unl_entry : S_DAT_OUT;
         S_DAT_OUT: if (abort_pend_q) nxt = unl_entry;
                    else if (tx_ready) nxt = last_word ? unl_entry : S_DAT_RD;
         S_UNL_RD:  if (mem_gnt) nxt = S_UNL_WT;
         S_UNL_WT:  nxt = S_UNL_WR;
         S_UNL_WR:  if (mem_gnt) nxt = S_FIN;
         S_FIN:     nxt = S_IDLE;
         default:   nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= S_IDLE;
         sa_q         <= '0;
         cnt_q        <= '0;
         idx_q        <= '0;
         ptr_q        <= '0;
         tag_q        <= '0;
         fresh_q      <= 1'b0;
         seen_q       <= 1'b0;
         abort_pend_q <= 1'b0;
         lock_q       <= 1'b0;
      end else begin
         state        <= nxt;
         abort_pend_q <= (state == S_IDLE) ? 1'b0 : (abort_pend_q | abort);
         if (state == S_IDLE && req_valid) begin
            sa_q    <= req_sa;
            cnt_q   <= req_count;
            idx_q   <= '0;
            fresh_q <= 1'b0;
            seen_q  <= 1'b0;
         end
         if (state == S_PTR_WT) ptr_q <= mem_rdata[AW-1:0];
         if (state == S_TAG_WT) begin
            tag_q   <= mem_rdata;
            fresh_q <= mem_rdata[UPD_BIT];
         end
         if (state == S_TAG_WR && mem_gnt) begin
            tag_q  <= lock_word;
            lock_q <= 1'b1;
         end
         if (state == S_UNL_WT) tag_q <= mem_rdata;
         if (state == S_UNL_WR && mem_gnt) lock_q <= 1'b0;
         if (state == S_DAT_OUT) seen_q <= 1'b1;
         if (state == S_FIN) seen_q <= 1'b0;
         if (state == S_DAT_OUT && !abort_pend_q && tx_ready) idx_q <= idx_q + CNT_W'(1);
      end
   end

   // ---------------- datapath pieces ----------------
   txb_tag_fmt #(.DW(DW), .LOCK_BIT(LOCK_BIT), .UPD_BIT(UPD_BIT)) u_fmt (
      .tag_in      (tag_q),
      .lock_word   (lock_word),
      .unlock_word (unlock_word)
   );

   txb_addr_gen #(.AW(AW), .SA_W(SA_W), .CNT_W(CNT_W), .PTR_BASE(PTR_BASE)) u_addr (
      .state (state),
      .sa    (sa_q),
      .ptr   (ptr_q),
      .idx   (idx_q),
      .addr  (mem_addr)
   );

   txb_word_reg #(.DW(DW)) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (state == S_DAT_WT),
      .din   (mem_rdata),
      .dout  (tx_data)
   );

   // ---------------- outputs ----------------
   assign mem_req    = (((state == S_PTR_RD) || (state == S_TAG_RD) || (state == S_DAT_RD))
                        && !abort_pend_q)
                       || (state == S_TAG_WR) || (state == S_UNL_RD) || (state == S_UNL_WR);
   assign mem_we     = (state == S_TAG_WR) || (state == S_UNL_WR);
   assign mem_lock   = txb_locked_state(state);
   assign mem_wdata  = (state == S_TAG_WR) ? lock_word :
                       (state == S_UNL_WR) ? unlock_word : '0;
   assign tx_valid   = (state == S_DAT_OUT) && !abort_pend_q;
   assign busy       = (state != S_IDLE);
   assign msg_done   = (state == S_FIN);
   assign lock_held  = lock_q;
   assign fresh_data = fresh_q && (seen_q || state == S_DAT_OUT);

   // ---------------- assertions ----------------
   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !mem_req && !busy && !tx_valid);

   p_rmw_lock_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_gnt && mem_lock && !mem_we |=> mem_lock);

   p_rmw_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock && $past(mem_lock) |-> $stable(mem_addr));

   p_claim_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && !lock_held |-> mem_wdata[LOCK_BIT] && !mem_wdata[UPD_BIT]);

   p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !abort |=> tx_valid && $stable(tx_data));

   p_fresh_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fresh_data && !msg_done |=> fresh_data);

   p_done_unlocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      msg_done |-> !lock_held);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      msg_done |=> !msg_done && !busy);

   p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt && !abort |=>
         mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

endmodule

// File: tb/txbuf_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module txbuf_lock_ctrl_tb_top;

   typedef struct packed {
      logic [4:0]  sa;
      logic [4:0]  cnt;
      logic [11:0] ptr;
      logic        upd;
      logic [13:0] low;
      logic        stall;
      logic        bp;
      logic [5:0]  exp_n;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{5'd1,  5'd4,  12'h100, 1'b1, 14'h1234, 1'b0, 1'b0, 6'd4},
      '{5'd7,  5'd1,  12'h140, 1'b0, 14'h0ABC, 1'b1, 1'b0, 6'd1},
      '{5'd31, 5'd0,  12'h180, 1'b1, 14'h3FFF, 1'b0, 1'b1, 6'd32},
      '{5'd0,  5'd31, 12'h200, 1'b0, 14'h0000, 1'b1, 1'b1, 6'd31},
      '{5'd16, 5'd9,  12'h240, 1'b1, 14'h2A5A, 1'b1, 1'b1, 6'd9}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [4:0]  req_sa = '0;
   logic [4:0]  req_count = '0;
   logic        abort = 1'b0;
   logic        busy, msg_done, fresh_data, lock_held;
   logic        mem_req, mem_we, mem_lock, mem_gnt;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata, tx_data;
   logic        tx_valid, tx_ready;

   logic        stall_en = 1'b0, bp_en = 1'b0, hold_gnt = 1'b0;
   logic        host_we = 1'b0;
   logic [9:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [7:0]  cyc = '0;
   logic [15:0] mem [0:1023];
   int          wr_cnt = 0;

   logic        mon_clr = 1'b0;
   int          n_got = 0, lock_seen = 0, done_cnt = 0;
   logic [15:0] got_data [64];
   logic        got_fresh [64];
   logic [15:0] first_tag = '0;
   logic [11:0] cur_ptr = '0;

   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   txbuf_lock_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sa(req_sa),
      .req_count(req_count), .abort(abort), .busy(busy), .msg_done(msg_done),
      .fresh_data(fresh_data), .lock_held(lock_held), .mem_req(mem_req),
      .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
   );

   assign mem_gnt  = !hold_gnt && (!stall_en || (cyc[1:0] != 2'b00));
   assign tx_ready = !bp_en || (cyc[2] ^ cyc[0]);

   // shared RAM with one-cycle read latency, plus a host write port
   always @(posedge clk) begin
      cyc <= cyc + 8'd1;
      if (host_we) mem[host_addr] <= host_wdata;
      if (mem_req && mem_gnt) begin
         if (mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr[9:0]];
         end
      end
   end

   // word monitor
   always begin
      @(negedge clk);
      #1;
      if (mon_clr) begin
         n_got = 0;
         lock_seen = 0;
      end else begin
         if (tx_valid && tx_ready && n_got < 64) begin
            if (n_got == 0) first_tag = mem[cur_ptr[9:0]];
            got_data[n_got]  = tx_data;
            got_fresh[n_got] = fresh_data;
            if (lock_held) lock_seen = lock_seen + 1;
            n_got = n_got + 1;
         end
      end
      if (msg_done) done_cnt = done_cnt + 1;
   end

   function automatic logic [15:0] dat(input logic [11:0] p, input int i);
      return {p[7:0] ^ 8'hC3, 8'(i) + 8'h11};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [11:0] a, input logic [15:0] d);
      host_we = 1'b1;
      host_addr = a[9:0];
      host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic load_table(input logic [4:0] sa, input logic [11:0] p, input logic upd,
                             input logic [13:0] low, input int n);
      host_wr({7'd0, sa}, {4'd0, p});
      host_wr(p, {1'b0, upd, low});
      for (int i = 0; i < n; i++) host_wr(p + 12'd1 + 12'(i), dat(p, i));
   endtask

   task automatic start_msg(input logic [4:0] sa, input logic [4:0] cnt, input logic [11:0] p);
      cur_ptr = p;
      mon_clr = 1'b1;
      @(negedge clk);
      mon_clr = 1'b0;
      req_valid = 1'b1;
      req_sa = sa;
      req_count = cnt;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
   endtask

   task automatic wait_done(input int d0);
      int t = 0;
      while (done_cnt == d0 && t < 4000) begin
         @(negedge clk);
         t++;
      end
      @(negedge clk);
      chk(done_cnt == d0 + 1, "R9 one done pulse", 32'(done_cnt - d0), 1);
      chk(busy == 1'b0, "R9 idle after done", 32'(busy), 0);
      chk(lock_held == 1'b0, "R11 released", 32'(lock_held), 0);
   endtask

   task automatic run_msg(input vec_t v);
      int d0, w0;
      load_table(v.sa, v.ptr, v.upd, v.low, (v.exp_n == 0) ? 1 : int'(v.exp_n));
      stall_en = v.stall;
      bp_en = v.bp;
      d0 = done_cnt;
      w0 = wr_cnt;
      start_msg(v.sa, v.cnt, v.ptr);
      wait_done(d0);
      chk(n_got == int'(v.exp_n), "R4 R5 word count", 32'(n_got), 32'(v.exp_n));
      for (int i = 0; i < n_got && i < 64; i++) begin
         chk(got_data[i] == dat(v.ptr, i), "R4 R10 word value", 32'(got_data[i]),
             32'(dat(v.ptr, i)));
         chk(got_fresh[i] == v.upd, "R6 fresh flag", 32'(got_fresh[i]), 32'(v.upd));
      end
      chk(first_tag == {2'b10, v.low}, "R3 tag while sending", 32'(first_tag),
          32'({2'b10, v.low}));
      chk(lock_seen == n_got, "R11 held during words", 32'(lock_seen), 32'(n_got));
      chk(mem[v.ptr[9:0]] == {2'b00, v.low}, "R7 tag after message",
          32'(mem[v.ptr[9:0]]), 32'({2'b00, v.low}));
      chk(wr_cnt - w0 == 2, "R3 R7 two tag writes", 32'(wr_cnt - w0), 2);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
      $finish;
   end

   initial begin
      int d0, w0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !msg_done && !fresh_data && !lock_held, "R1 status idle",
          {busy, msg_done, fresh_data, lock_held}, 0);
      chk(!tx_valid && !mem_req, "R1 no traffic", {tx_valid, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 5; v++) run_msg(VEC[v]);

      // R8: abort while idle is ignored, the next message runs in full
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      run_msg('{5'd3, 5'd6, 12'h2C0, 1'b1, 14'h0F0F, 1'b0, 1'b1, 6'd6});

      // R2: pointer entry moved mid-message; words still come from the first table
      load_table(5'd9, 12'h340, 1'b0, 14'h0777, 8);
      load_table(5'd9, 12'h300, 1'b1, 14'h1111, 8);
      stall_en = 1'b1;
      bp_en = 1'b1;
      d0 = done_cnt;
      start_msg(5'd9, 5'd8, 12'h300);
      while (n_got < 2) @(negedge clk);
      host_wr(12'd9, 16'h0340);
      wait_done(d0);
      chk(n_got == 8, "R2 word count after swap", 32'(n_got), 8);
      for (int i = 0; i < 8; i++)
         chk(got_data[i] == dat(12'h300, i), "R2 words from captured pointer",
             32'(got_data[i]), 32'(dat(12'h300, i)));
      chk(mem[10'h340] == 16'h0777, "R2 other table untouched", 32'(mem[10'h340]), 32'h0777);

      // R8: abort before the tag update -> no RAM write, tag untouched
      load_table(5'd12, 12'h380, 1'b1, 14'h2222, 4);
      stall_en = 1'b0;
      bp_en = 1'b0;
      hold_gnt = 1'b1;
      d0 = done_cnt;
      w0 = wr_cnt;
      start_msg(5'd12, 5'd4, 12'h380);
      @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      wait_done(d0);
      hold_gnt = 1'b0;
      repeat (2) @(negedge clk);
      chk(wr_cnt == w0, "R8 no write on early abort", 32'(wr_cnt - w0), 0);
      chk(mem[10'h380] == 16'h6222, "R8 tag kept on early abort", 32'(mem[10'h380]), 32'h6222);
      chk(n_got == 0, "R8 no words on early abort", 32'(n_got), 0);
      chk(fresh_data == 1'b0, "R6 no fresh flag without words", 32'(fresh_data), 0);

      // R8: abort after some words -> stop and release the table
      load_table(5'd5, 12'h3C0, 1'b1, 14'h1357, 16);
      bp_en = 1'b1;
      d0 = done_cnt;
      start_msg(5'd5, 5'd16, 12'h3C0);
      while (n_got < 3) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      wait_done(d0);
      chk(n_got < 16, "R8 words cut short", 32'(n_got), 16);
      chk(mem[10'h3C0] == 16'h1357, "R8 R7 tag released after abort",
          32'(mem[10'h3C0]), 32'h1357);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule